// File: doc/BRIEF.md
# Dual Event Performance Counter

This block gives a processor core two independent 48-bit event counters. Each counter has its own control word. The control word picks one event source through a 6-bit code, starts or stops counting, and can ask for the count to be cleared. The core supplies single-cycle event pulses, such as branches, taken branches, executed instructions, FPU instructions, interrupts and non-maskable interrupts. It also supplies a free-running time tick. A prescaler divides that tick before it reaches the elapsed-time event.

Software-facing access goes through a small word-addressed port. A write reaches only the two control addresses. A read returns one 32-bit word exactly one cycle later. Each counter is read as a masked high word, holding bits 47:32 with the top 16 bits zero, and a separate low word.

The block has no stream interface. Every pin is a plain control or status signal, and the read and write strobes cannot be back-pressured. Address map: 0 reads zero; 1 and 2 are the high and low words of counter 0; 3 and 4 are the high and low words of counter 1; 5 and 6 are the control words of counter 0 and counter 1.

Top module: `dual_perf_counter`

## Requirements
- R1: After reset both counts read zero and both active event codes read zero (idle).
- R2: A control write with bits 15 and 14 both set makes bits 5:0 the counter's active code. A write without both bits stops the counter, sets its active code to zero and keeps the count.
- R3: Control bit 13 zeroes the count only if the counter was idle when the write arrived. It is ignored while the counter is running, even if the same write stops it.
- R4: Codes 0x10, 0x11, 0x13, 0x15, 0x16 and 0x17 count pulses on `evt_pulse` bits 0 to 5 respectively: branch, taken branch, instruction, FPU instruction, interrupt and NMI.
- R5: Code 0x23 adds one for every TICK_DIV cycles with `time_tick` high. The prescaler restarts from zero whenever the counter's code is not 0x23.
- R6: Any other nonzero code adds nothing to the count while the counter runs.
- R7: A count grows by exactly one in each cycle in which its selected event is present, and it wraps modulo 2^48.
- R8: A read of a high address returns count bits 47:32 in bits 15:0, with bits 31:16 zero. A read of a low address returns bits 31:0.
- R9: Address 0 and unmapped addresses read as zero. Writes to counter-value addresses change nothing.
- R10: `rd_data` is valid in the cycle after `rd_en`, marked by `rd_valid`. A read of a control address returns the active code in bits 5:0.
- R11: The two counters run independently, each on its own code and events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Word address |
| wr_data | input | 16 | Control write data |
| evt_pulse | input | 6 | Single-cycle event pulses from the core |
| time_tick | input | 1 | Free-running elapsed-time tick |
| rd_data | output | 32 | Read data |
| rd_valid | output | 1 | Read data valid |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that an event pulse seen while a control write lands is counted under the code that was active before that write. The bench keeps these apart: it drives every write, read and event burst in its own cycles, and changes inputs only on the falling edge. Expected counts are kept in bench variables that follow the requirements, and they are compared through register reads only.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CODE_W = 6;
  localparam int EVT_N  = 6;
  typedef logic [CODE_W-1:0] evt_code_t;

  localparam evt_code_t CODE_IDLE    = 6'h00;
  localparam evt_code_t CODE_BRANCH  = 6'h10;
  localparam evt_code_t CODE_BR_TKN  = 6'h11;
  localparam evt_code_t CODE_INSN    = 6'h13;
  localparam evt_code_t CODE_FPU     = 6'h15;
  localparam evt_code_t CODE_IRQ     = 6'h16;
  localparam evt_code_t CODE_NMI     = 6'h17;
  localparam evt_code_t CODE_ELAPSED = 6'h23;

  localparam int RUN_HI_BIT = 15;
  localparam int RUN_LO_BIT = 14;
  localparam int CLR_BIT    = 13;
endpackage

// File: rtl/pmu_event_sel.sv
module pmu_event_sel
  import pmu_pkg::*;
(
  input  evt_code_t        code,
  input  logic [EVT_N-1:0] evt,
  input  logic             elapsed_step,
  output logic             hit
);
  always_comb begin
    unique case (code)
      CODE_BRANCH:  hit = evt[0];
      CODE_BR_TKN:  hit = evt[1];
      CODE_INSN:    hit = evt[2];
      CODE_FPU:     hit = evt[3];
      CODE_IRQ:     hit = evt[4];
      CODE_NMI:     hit = evt[5];
      CODE_ELAPSED: hit = elapsed_step;
      default:      hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
  import pmu_pkg::*;
#(
  parameter int CNT_W    = 48,
  parameter int TICK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_run,
  input  logic             ctl_clr,
  input  evt_code_t        ctl_code,
  input  logic [EVT_N-1:0] evt,
  input  logic             time_tick,
  output logic [CNT_W-1:0] count,
  output evt_code_t        code
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic             elapsed_mode, step, hit, idle;

  assign elapsed_mode = (code == CODE_ELAPSED);
  assign idle         = (code == CODE_IDLE);
  assign step         = elapsed_mode && time_tick && (pre_q == PRE_LAST);

  pmu_event_sel u_sel (
    .code         (code),
    .evt          (evt),
    .elapsed_step (step),
    .hit          (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (!elapsed_mode) pre_q <= '0;
    else if (time_tick) pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code <= CODE_IDLE;
    else if (ctl_wr) code <= ctl_run ? ctl_code : CODE_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (ctl_wr && ctl_clr && idle) count <= '0;
    else if (hit) count <= count + 1'b1;
  end

  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0));
  assert_clear_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_clr && !idle && count != '0 && count != '1) |=> count != '0);
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !(ctl_wr && ctl_clr)) |=> $stable(count));
  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_run) |=> code == CODE_IDLE);
  assert_pre_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!elapsed_mode) |=> pre_q == '0);
endmodule

// File: rtl/pmu_read_mux.sv
module pmu_read_mux
  import pmu_pkg::*;
#(
  parameter int NUM_CTR = 2,
  parameter int CNT_W   = 48,
  parameter int ADDR_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NUM_CTR-1:0][CNT_W-1:0] counts,
  input  evt_code_t [NUM_CTR-1:0]       codes,
  output logic [31:0]                   rd_data,
  output logic                          rd_valid
);
  localparam int HI_W     = CNT_W - 32;
  localparam int CTL_BASE = 1 + 2 * NUM_CTR;

  logic [31:0] sel_word;
  logic        is_high;

  always_comb begin
    sel_word = '0;
    is_high  = 1'b0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (addr == ADDR_W'(1 + 2 * i)) begin
        sel_word = {{(32 - HI_W){1'b0}}, counts[i][CNT_W-1:32]};
        is_high  = 1'b1;
      end
      if (addr == ADDR_W'(2 + 2 * i)) sel_word = counts[i][31:0];
      if (addr == ADDR_W'(CTL_BASE + i)) sel_word = {{(32 - CODE_W){1'b0}}, codes[i]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel_word;
    end
  end

  assert_high_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_high) |=> rd_data[31:16] == 16'h0);
  assert_zero_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == '0) |=> rd_data == 32'h0);
  assert_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

// File: rtl/dual_perf_counter.sv
module dual_perf_counter
  import pmu_pkg::*;
#(
  parameter int NUM_CTR  = 2,
  parameter int CNT_W    = 48,
  parameter int ADDR_W   = 3,
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wr_data,
  input  logic [EVT_N-1:0]  evt_pulse,
  input  logic              time_tick,
  output logic [31:0]       rd_data,
  output logic              rd_valid
);
  localparam int CTL_BASE = 1 + 2 * NUM_CTR;

  logic [NUM_CTR-1:0][CNT_W-1:0] counts;
  evt_code_t [NUM_CTR-1:0]       codes;
  logic                          ctl_run, ctl_clr;
  logic [6:0]                    unused_bits;

  assign ctl_run     = wr_data[RUN_HI_BIT] && wr_data[RUN_LO_BIT];
  assign ctl_clr     = wr_data[CLR_BIT];
  assign unused_bits = wr_data[12:6];

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    logic sel_wr;
    assign sel_wr = wr_en && (addr == ADDR_W'(CTL_BASE + g));
    pmu_counter #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (sel_wr),
      .ctl_run   (ctl_run),
      .ctl_clr   (ctl_clr),
      .ctl_code  (wr_data[CODE_W-1:0]),
      .evt       (evt_pulse),
      .time_tick (time_tick),
      .count     (counts[g]),
      .code      (codes[g])
    );
  end

  pmu_read_mux #(.NUM_CTR(NUM_CTR), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .addr     (addr),
    .counts   (counts),
    .codes    (codes),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );
endmodule

// File: tb/test_dual_perf_counter.sv
module test_dual_perf_counter;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, time_tick = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  evt_pulse = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  int checks = 0, errors = 0;
  int exp0 = 0, exp1 = 0;
  logic [31:0] r;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_perf_counter #(.TICK_DIV(TDIV)) i_dual_perf_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .evt_pulse(evt_pulse), .time_tick(time_tick),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    if (rd_valid !== 1'b1) begin
      checks++; errors++;
      $display("FAIL R10 actual=%b expected=1", rd_valid);
    end
    d = rd_data;
  endtask

  task automatic pulse(input logic [5:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt_pulse = m;
      @(negedge clk); evt_pulse = '0;
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk); time_tick = 1'b1;
    for (int i = 1; i < n; i++) @(negedge clk);
    @(negedge clk); time_tick = 1'b0;
  endtask

  task automatic t_reset();
    for (int a = 1; a <= 6; a++) begin
      rd(3'(a), r); chk("R1 reset value", r, 0);
    end
  endtask

  task automatic t_run_events();
    wr(5, 16'hC013);
    rd(5, r); chk("R10 control readback", r, 32'h13);
    pulse(6'b000100, 5); pulse(6'b000001, 3); exp0 = 5;
    rd(2, r); chk("R4 insn count", r, exp0);
    rd(1, r); chk("R8 high word", r, 0);
    wr(5, 16'hC010);
    pulse(6'b000001, 3); pulse(6'b000100, 2); exp0 = 8;
    rd(2, r); chk("R2 switch code while running", r, exp0);
    pulse(6'b111111, 2); exp0 = 10;
    rd(2, r); chk("R7 one per cycle", r, exp0);
    wr(5, 16'h8010);
    rd(5, r); chk("R2 stop sets idle", r, 0);
    pulse(6'b111111, 3);
    rd(2, r); chk("R2 stopped count held", r, exp0);
    wr(5, 16'h4011);
    rd(5, r); chk("R2 one run bit stays idle", r, 0);
  endtask

  task automatic t_clear();
    wr(5, 16'h2000); exp0 = 0;
    rd(2, r); chk("R3 clear while idle", r, exp0);
    wr(5, 16'hC010); pulse(6'b000001, 2); exp0 = 2;
    wr(5, 16'hE010);
    rd(2, r); chk("R3 clear ignored while running", r, exp0);
    rd(5, r); chk("R3 still running", r, 32'h10);
    wr(5, 16'h2000);
    rd(2, r); chk("R3 clear with stop ignored", r, exp0);
    wr(5, 16'h2000); exp0 = 0;
    rd(2, r); chk("R3 second clear honoured", r, exp0);
    wr(5, 16'hC010); pulse(6'b000001, 4); wr(5, 16'h0000);
    wr(5, 16'hE011); pulse(6'b000010, 1); exp0 = 1;
    rd(2, r); chk("R3 clear and start from idle", r, exp0);
    wr(5, 16'h0000);
  endtask

  task automatic t_elapsed();
    wr(6, 16'hC023); ticks(10); exp1 = 10 / TDIV;
    rd(4, r); chk("R5 elapsed divide", r, exp1);
    wr(6, 16'h0000); wr(6, 16'hC023); ticks(TDIV - 1);
    wr(6, 16'h0000);
    rd(4, r); chk("R5 partial period", r, exp1);
    wr(6, 16'hC023); ticks(TDIV); exp1++;
    rd(4, r); chk("R5 prescaler restarts", r, exp1);
    wr(6, 16'h0000);
  endtask

  task automatic t_undefined();
    wr(6, 16'hC03F); pulse(6'b111111, 3); ticks(2 * TDIV);
    rd(4, r); chk("R6 code 0x3F adds nothing", r, exp1);
    wr(6, 16'hC001); pulse(6'b111111, 3); ticks(2 * TDIV);
    rd(4, r); chk("R6 code 0x01 adds nothing", r, exp1);
    wr(6, 16'h0000);
  endtask

  task automatic t_read_map();
    rd(0, r); chk("R9 address 0", r, 0);
    rd(7, r); chk("R9 unmapped address", r, 0);
    wr(2, 16'hFFFF); wr(1, 16'hC013);
    rd(2, r); chk("R9 write to low ignored", r, exp0);
    rd(1, r); chk("R9 write to high ignored", r, 0);
    rd(5, r); chk("R9 control untouched", r, 0);
    rd(3, r); chk("R8 counter 1 high", r, 0);
  endtask

  task automatic t_independent();
    wr(5, 16'hC016); wr(6, 16'hC017);
    pulse(6'b010000, 2); pulse(6'b100000, 3); pulse(6'b110000, 1);
    exp0 += 3; exp1 += 4;
    rd(2, r); chk("R11 counter 0", r, exp0);
    rd(4, r); chk("R11 counter 1", r, exp1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_run_events();
    t_clear();
    t_elapsed();
    t_undefined();
    t_read_map();
    t_independent();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule